// File: doc/BRIEF.md
# Host Port Access Master

This block sits on the host side of a 16-bit parallel port with four registers on a peripheral controller. Every access to the peripheral's memory goes through the port's address register: the target address is written there first, then the data register is read or written one or more times while the peripheral advances its own pointer after each access. The block takes one request at a time on a valid/ready interface. A request can be a single word read or write, a burst read or write, a mailbox read or write, a status read, or an atomic bit set or bit clear. The block turns each request into the right series of bus cycles.

Each bus cycle drives chip select together with a read or a write strobe for a set number of clock cycles. Between the end of one strobe and the start of the next there is always a minimum number of idle clock cycles. Burst data is exchanged on a word stream. Each stream word has its two bytes in the opposite order to the bus word. Addresses and single-word data go to the bus unchanged. A bit set or bit clear runs as one request, so no other request can reach the port between its read and its write.

Top module: `hpi_access_master`

## Requirements
- R1: After reset, `req_ready_o` is 1, `done_o` and `beat_o` are 0, and `bus_cs_no`, `bus_rd_no` and `bus_wr_no` are all 1.
- R2: `bus_cs_no` is low exactly while one strobe is low, and the two strobes are never low together. Each strobe lasts STROBE_CYC clocks, and the address and write data stay stable while it is low. `bus_addr_o` equals the register index times STRIDE, where index 0 is data, 1 is mailbox, 2 is address and 3 is status.
- R3: Between the end of one strobe and the start of the next there are at least GAP_CYC clock cycles with no strobe.
- R4: Op code 0 (single read) writes `req_addr_i` to the address register and then reads the data register once. The word read is returned as-is.
- R5: Op code 1 (single write) writes `req_addr_i` to the address register and then writes `req_wdata_i` to the data register.
- R6: Op code 2 (burst read) with `req_len_i`=N>0 writes the address register once and then does N data register reads. Each read emits a `beat_o` pulse with the bus word byte-swapped on `rd_data_o`.
- R7: Op code 3 (burst write) with N>0 writes the address register once and then does N data register writes. Each write consumes one stream word, marked by a `bwr_take_o` pulse, and drives it byte-swapped onto the bus.
- R8: A burst (op code 2 or 3) with `req_len_i`=0 does only the address register write, then completes with no data cycle, no beat and no take.
- R9: Op code 5 writes `req_wdata_i` to the mailbox register and op code 4 reads it. Each is a single cycle with no address register write.
- R10: Op code 6 reads the status register in a single cycle with no address register write.
- R11: Op code 7 (set) and op code 8 (clear) each run four cycles: address write, data read, address write, then data write of read|`req_wdata_i` or read&~`req_wdata_i`. `rd_data_o` returns the old value.
- R12: A request is accepted only while `req_ready_o` is 1. A `req_valid_i` presented while the block is busy is ignored.
- R13: `done_o` pulses for one cycle when a request's last bus cycle ends. `req_ready_o` is 1 in that cycle, and `rd_data_o` holds the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_op_i | input | 4 | Request op code (0..8) |
| req_addr_i | input | 16 | Peripheral memory address |
| req_wdata_i | input | 16 | Write value or bit mask |
| req_len_i | input | LEN_W | Burst word count |
| bwr_data_i | input | 16 | Burst write stream word |
| bwr_take_o | output | 1 | Stream word consumed |
| beat_o | output | 1 | Burst read word on `rd_data_o` |
| done_o | output | 1 | Request completed |
| rd_data_o | output | 16 | Read word |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_addr_o | output | ADDR_W | Register byte offset |
| bus_dq_o | output | 16 | Bus write data |
| bus_dq_oe_o | output | 1 | Bus data output enable |
| bus_dq_i | input | 16 | Bus read data |

## Verification
The hardest case to reach from the ports is a request that arrives while another request is still running, above all in the middle of a bit set or clear. A request that slipped in there could change memory between the read and the write. The bench starts a write and then holds `req_valid_i` high with a different write for several busy cycles. It then reads the second target back through the port to show that the stray request left it untouched. Random sequences mix set, clear, single and burst accesses at overlapping addresses, so that each read-modify-write result depends on the data that earlier bursts left there.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    OP_RD   = 4'd0,
    OP_WR   = 4'd1,
    OP_BRD  = 4'd2,
    OP_BWR  = 4'd3,
    OP_MBRD = 4'd4,
    OP_MBWR = 4'd5,
    OP_STAT = 4'd6,
    OP_SET  = 4'd7,
    OP_CLR  = 4'd8
  } hpi_op_e;

  typedef enum logic [1:0] {
    IDX_DATA = 2'd0,
    IDX_MBOX = 2'd1,
    IDX_ADDR = 2'd2,
    IDX_STAT = 2'd3
  } hpi_idx_e;

  function automatic logic [WORD_W-1:0] swap16(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/hpi_gap_timer.sv
module hpi_gap_timer #(
  parameter int GAP_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ok_o
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

  logic [GW-1:0] cnt_q;

  // loaded on the last strobe cycle, reaches zero after GAP_CYC idle cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= GW'(GAP_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/hpi_bus_cycle.sv
module hpi_bus_cycle
  import hpi_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STRIDE     = 2,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  hpi_idx_e          idx_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_dq_o,
  output logic              bus_dq_oe_o,
  input  logic [WORD_W-1:0] bus_dq_i
);
  localparam int SW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  typedef enum logic [1:0] {CY_IDLE, CY_PEND, CY_STRB} cy_e;

  cy_e               st_q;
  hpi_idx_e          idx_q;
  logic              we_q, done_q;
  logic [WORD_W-1:0] wd_q, rd_q;
  logic [SW-1:0]     scnt_q;
  logic              gap_ok, strobe, last;

  assign strobe = (st_q == CY_STRB);
  assign last   = strobe && (scnt_q == '0);

  hpi_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last),
    .ok_o   (gap_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CY_IDLE;
      idx_q  <= IDX_DATA;
      we_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      scnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        CY_IDLE: if (start_i) begin
          idx_q <= idx_i;
          we_q  <= we_i;
          wd_q  <= wdata_i;
          st_q  <= CY_PEND;
        end
        CY_PEND: if (gap_ok) begin
          scnt_q <= SW'(STROBE_CYC - 1);
          st_q   <= CY_STRB;
        end
        CY_STRB: begin
          if (last) begin
            if (!we_q) rd_q <= bus_dq_i;
            done_q <= 1'b1;
            st_q   <= CY_IDLE;
          end else begin
            scnt_q <= scnt_q - 1'b1;
          end
        end
        default: st_q <= CY_IDLE;
      endcase
    end
  end

  assign ready_o     = (st_q == CY_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rd_q;
  assign bus_cs_no   = !strobe;
  assign bus_rd_no   = !(strobe && !we_q);
  assign bus_wr_no   = !(strobe && we_q);
  assign bus_addr_o  = ADDR_W'(int'(idx_q) * STRIDE);
  assign bus_dq_o    = wd_q;
  assign bus_dq_oe_o = we_q && (st_q != CY_IDLE);
endmodule

// File: rtl/hpi_access_master.sv
module hpi_access_master
  import hpi_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STRIDE     = 2,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 6,
  parameter int LEN_W      = 8,
  parameter bit SWAP_BURST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_op_i,
  input  logic [15:0]       req_addr_i,
  input  logic [15:0]       req_wdata_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [15:0]       bwr_data_i,
  output logic              bwr_take_o,
  output logic              beat_o,
  output logic              done_o,
  output logic [15:0]       rd_data_o,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_dq_o,
  output logic              bus_dq_oe_o,
  input  logic [15:0]       bus_dq_i
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_WADDR, SQ_WDATA} sq_e;

  sq_e               sq_q;
  hpi_op_e           op_q;
  logic [15:0]       addr_q, wd_q, rmw_q, rd_q;
  logic [LEN_W-1:0]  left_q;
  logic              issued_q, done_q, beat_q;

  logic              cyc_start, cyc_ready, cyc_done, cyc_we;
  hpi_idx_e          cyc_idx;
  logic [15:0]       cyc_wd, cyc_rd, burst_wd, burst_rd;
  logic              is_burst;

  assign is_burst = (op_q == OP_BRD) || (op_q == OP_BWR);
  assign burst_wd = SWAP_BURST ? swap16(bwr_data_i) : bwr_data_i;
  assign burst_rd = SWAP_BURST ? swap16(cyc_rd) : cyc_rd;

  always_comb begin
    cyc_idx = IDX_DATA;
    cyc_we  = 1'b0;
    cyc_wd  = '0;
    unique case (sq_q)
      SQ_ADDR, SQ_WADDR: begin
        cyc_idx = IDX_ADDR;
        cyc_we  = 1'b1;
        cyc_wd  = addr_q;
      end
      SQ_DATA: begin
        unique case (op_q)
          OP_MBRD: cyc_idx = IDX_MBOX;
          OP_MBWR: begin cyc_idx = IDX_MBOX; cyc_we = 1'b1; cyc_wd = wd_q; end
          OP_STAT: cyc_idx = IDX_STAT;
          OP_WR:   begin cyc_we = 1'b1; cyc_wd = wd_q; end
          OP_BWR:  begin cyc_we = 1'b1; cyc_wd = burst_wd; end
          default: cyc_we = 1'b0;
        endcase
      end
      SQ_WDATA: begin
        cyc_we = 1'b1;
        cyc_wd = (op_q == OP_SET) ? (rmw_q | wd_q) : (rmw_q & ~wd_q);
      end
      default: cyc_we = 1'b0;
    endcase
  end

  assign cyc_start  = (sq_q != SQ_IDLE) && !issued_q && cyc_ready;
  assign bwr_take_o = cyc_start && (sq_q == SQ_DATA) && (op_q == OP_BWR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q     <= SQ_IDLE;
      op_q     <= OP_RD;
      addr_q   <= '0;
      wd_q     <= '0;
      rmw_q    <= '0;
      rd_q     <= '0;
      left_q   <= '0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      beat_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      beat_q <= 1'b0;
      if (cyc_start) issued_q <= 1'b1;
      unique case (sq_q)
        SQ_IDLE: if (req_valid_i) begin
          op_q   <= hpi_op_e'(req_op_i);
          addr_q <= req_addr_i;
          wd_q   <= req_wdata_i;
          left_q <= req_len_i;
          sq_q   <= (req_op_i inside {OP_MBRD, OP_MBWR, OP_STAT}) ? SQ_DATA : SQ_ADDR;
        end
        SQ_ADDR: if (cyc_done) begin
          issued_q <= 1'b0;
          if (is_burst && left_q == '0) begin
            sq_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end else begin
            sq_q <= SQ_DATA;
          end
        end
        SQ_DATA: if (cyc_done) begin
          issued_q <= 1'b0;
          if (!cyc_we) rd_q <= (op_q == OP_BRD) ? burst_rd : cyc_rd;
          if (op_q == OP_BRD) beat_q <= 1'b1;
          if (is_burst && left_q > LEN_W'(1)) begin
            left_q <= left_q - 1'b1;
          end else if (op_q == OP_SET || op_q == OP_CLR) begin
            rmw_q <= cyc_rd;
            sq_q  <= SQ_WADDR;
          end else begin
            sq_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end
        end
        SQ_WADDR: if (cyc_done) begin
          issued_q <= 1'b0;
          sq_q     <= SQ_WDATA;
        end
        SQ_WDATA: if (cyc_done) begin
          issued_q <= 1'b0;
          sq_q     <= SQ_IDLE;
          done_q   <= 1'b1;
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  hpi_bus_cycle #(
    .ADDR_W     (ADDR_W),
    .STRIDE     (STRIDE),
    .STROBE_CYC (STROBE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_cyc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cyc_start),
    .idx_i       (cyc_idx),
    .we_i        (cyc_we),
    .wdata_i     (cyc_wd),
    .ready_o     (cyc_ready),
    .done_o      (cyc_done),
    .rdata_o     (cyc_rd),
    .bus_cs_no   (bus_cs_no),
    .bus_rd_no   (bus_rd_no),
    .bus_wr_no   (bus_wr_no),
    .bus_addr_o  (bus_addr_o),
    .bus_dq_o    (bus_dq_o),
    .bus_dq_oe_o (bus_dq_oe_o),
    .bus_dq_i    (bus_dq_i)
  );

  assign req_ready_o = (sq_q == SQ_IDLE);
  assign done_o      = done_q;
  assign beat_o      = beat_q;
  assign rd_data_o   = rd_q;
endmodule

// File: rtl/hpi_access_master_chk.sv
module hpi_access_master_chk #(
  parameter int ADDR_W  = 4,
  parameter int GAP_CYC = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              bus_cs_no,
  input logic              bus_rd_no,
  input logic              bus_wr_no,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [15:0]       bus_dq_o,
  input logic              bus_dq_oe_o
);
  localparam int CW = $clog2(GAP_CYC + 2);

  logic          strb, strb_q, seen_q;
  logic [CW-1:0] off_q;

  assign strb = !bus_rd_no || !bus_wr_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      seen_q <= 1'b0;
      off_q  <= '0;
    end else begin
      strb_q <= strb;
      if (strb) begin
        seen_q <= 1'b1;
        off_q  <= '0;
      end else if (off_q < CW'(GAP_CYC)) begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  a_r2_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));

  a_r2_cs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no) == strb);

  a_r2_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb && strb_q |-> $stable(bus_addr_o) && $stable(bus_dq_o));

  a_r2_wr_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_no |-> bus_dq_oe_o);

  a_r3_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb && !strb_q && seen_q |-> off_q >= CW'(GAP_CYC));

  a_r13_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind hpi_access_master hpi_access_master_chk #(
  .ADDR_W  (ADDR_W),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .bus_cs_no   (bus_cs_no),
  .bus_rd_no   (bus_rd_no),
  .bus_wr_no   (bus_wr_no),
  .bus_addr_o  (bus_addr_o),
  .bus_dq_o    (bus_dq_o),
  .bus_dq_oe_o (bus_dq_oe_o)
);

// File: tb/hpi_access_master_tb.sv
module hpi_access_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int STRIDE     = 2;
  localparam int STROBE_CYC = 2;
  localparam int GAP_CYC    = 6;
  localparam int LEN_W      = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_op = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [15:0] bwr_data, rd_data, dq_o, dq_in;
  logic bwr_take, beat, done, cs_n, rd_n, wr_n, dq_oe;
  logic [ADDR_W-1:0] bus_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpi_access_master #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .STROBE_CYC(STROBE_CYC),
    .GAP_CYC(GAP_CYC), .LEN_W(LEN_W), .SWAP_BURST(1'b1)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_len_i(req_len),
    .bwr_data_i(bwr_data), .bwr_take_o(bwr_take), .beat_o(beat),
    .done_o(done), .rd_data_o(rd_data),
    .bus_cs_no(cs_n), .bus_rd_no(rd_n), .bus_wr_no(wr_n),
    .bus_addr_o(bus_addr), .bus_dq_o(dq_o), .bus_dq_oe_o(dq_oe),
    .bus_dq_i(dq_in)
  );

  int nchk = 0, nerr = 0;

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral model
  logic [15:0] dmem [128];
  logic [15:0] ref_mem [128];
  logic [15:0] aptr = '0, mbox_in = '0;
  localparam logic [15:0] MBOX_OUT = 16'hC0DE;
  localparam logic [15:0] STAT_VAL = 16'h00A5;

  always_comb begin
    case (int'(bus_addr) / STRIDE)
      0: dq_in = dmem[aptr[7:1]];
      1: dq_in = MBOX_OUT;
      2: dq_in = aptr;
      default: dq_in = STAT_VAL;
    endcase
  end

  // burst write stream source
  logic [15:0] src [256];
  logic [7:0] bidx = '0;
  assign bwr_data = src[bidx];
  always @(posedge clk) if (bwr_take) bidx <= bidx + 8'd1;

  // burst read capture and bus cycle log
  logic [15:0] rbuf [256];
  logic [7:0] bcnt = '0;
  logic lg_we [2048];
  logic [1:0] lg_idx [2048];
  logic [15:0] lg_d [2048];
  int lc = 0, bad_pin = 0, min_gap = 1000, off_cnt = 0;
  bit seen = 0, prev = 0, lat_we = 0;
  int lat_idx = 0;
  logic [15:0] lat_d = '0;

  always @(negedge clk) begin
    bit strb;
    strb = !cs_n;
    if (rst_n) begin
      if (!cs_n != (!rd_n || !wr_n) || (!rd_n && !wr_n)) bad_pin++;
      if (strb && !prev) begin
        if (seen && off_cnt < min_gap) min_gap = off_cnt;
        seen = 1;
        if (int'(bus_addr) % STRIDE != 0) bad_pin++;
        if (lc < 2048) begin
          lg_we[lc]  = !wr_n;
          lg_idx[lc] = 2'(int'(bus_addr) / STRIDE);
          lg_d[lc]   = !wr_n ? dq_o : dq_in;
        end
        lc++;
      end
      if (strb) begin
        if (prev && (lat_idx != int'(bus_addr) / STRIDE || (lat_we && lat_d != dq_o))) bad_pin++;
        lat_we = !wr_n; lat_idx = int'(bus_addr) / STRIDE; lat_d = dq_o;
        off_cnt = 0;
      end else begin
        off_cnt++;
      end
      if (!strb && prev) begin
        if (lat_we) begin
          case (lat_idx)
            0: begin dmem[aptr[7:1]] = lat_d; aptr = aptr + 16'd2; end
            1: mbox_in = lat_d;
            2: aptr = lat_d;
            default: ;
          endcase
        end else if (lat_idx == 0) begin
          aptr = aptr + 16'd2;
        end
      end
      if (beat) begin rbuf[bcnt] = rd_data; bcnt = bcnt + 8'd1; end
      prev = strb;
    end
  end

  task automatic exp_cyc(input int k, input bit we, input int idx, input logic [15:0] d, input string tag);
    chk(lg_we[k] == we && lg_idx[k] == 2'(idx) && lg_d[k] == d, tag,
        {13'd0, lg_we[k], lg_idx[k], lg_d[k]}, {13'd0, we, 2'(idx), d});
  endtask

  task automatic do_req(input logic [3:0] op, input logic [15:0] a, input logic [15:0] wd,
                        input int len, output logic [15:0] rd);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R13 done pulse seen", {31'd0, done}, 32'd1);
    chk(req_ready, "R13 ready with done", {31'd0, req_ready}, 32'd1);
    rd = rd_data;
    @(negedge clk);
    chk(!done, "R13 done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] r, old, m;
    int ls;
    logic [7:0] base;
    void'($urandom(32'd1357));
    for (int i = 0; i < 128; i++) begin
      dmem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      ref_mem[i] = dmem[i];
    end
    for (int i = 0; i < 256; i++) src[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !done && !beat && cs_n && rd_n && wr_n, "R1 reset outputs",
        {26'd0, req_ready, done, beat, cs_n, rd_n, wr_n}, {26'd0, 6'b100111});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 single write
    ls = lc;
    do_req(4'd1, 16'h0010, 16'hBEEF, 0, r);
    chk(lc - ls == 2, "R5 cycle count", 32'(lc - ls), 32'd2);
    exp_cyc(ls, 1, 2, 16'h0010, "R5 address write");
    exp_cyc(ls + 1, 1, 0, 16'hBEEF, "R5 data write");
    ref_mem[8] = 16'hBEEF;
    chk(dmem[8] == 16'hBEEF, "R5 memory", {16'd0, dmem[8]}, 32'hBEEF);

    // R4 single read
    ls = lc;
    do_req(4'd0, 16'h0010, 16'h0, 0, r);
    chk(lc - ls == 2, "R4 cycle count", 32'(lc - ls), 32'd2);
    exp_cyc(ls, 1, 2, 16'h0010, "R4 address write");
    exp_cyc(ls + 1, 0, 0, 16'hBEEF, "R4 data read");
    chk(r == 16'hBEEF, "R4 read data", {16'd0, r}, 32'hBEEF);

    // R7 burst write
    ls = lc; base = bidx;
    do_req(4'd3, 16'h0020, 16'h0, 4, r);
    chk(lc - ls == 5, "R7 cycle count", 32'(lc - ls), 32'd5);
    chk(bidx == 8'(base + 4), "R7 take count", {24'd0, bidx}, {24'd0, 8'(base + 4)});
    exp_cyc(ls, 1, 2, 16'h0020, "R7 address write");
    for (int i = 0; i < 4; i++) begin
      exp_cyc(ls + 1 + i, 1, 0, swp(src[8'(base + i)]), "R7 swapped data write");
      ref_mem[16 + i] = swp(src[8'(base + i)]);
      chk(dmem[16 + i] == ref_mem[16 + i], "R7 memory", {16'd0, dmem[16 + i]}, {16'd0, ref_mem[16 + i]});
    end

    // R6 burst read
    ls = lc; base = bcnt;
    do_req(4'd2, 16'h0020, 16'h0, 4, r);
    chk(lc - ls == 5, "R6 cycle count", 32'(lc - ls), 32'd5);
    chk(bcnt == 8'(base + 4), "R6 beat count", {24'd0, bcnt}, {24'd0, 8'(base + 4)});
    for (int i = 0; i < 4; i++)
      chk(rbuf[8'(base + i)] == src[8'(i + bidx - 4)], "R6 swapped stream word",
          {16'd0, rbuf[8'(base + i)]}, {16'd0, src[8'(i + bidx - 4)]});

    // R8 zero-length bursts
    ls = lc; base = bcnt;
    do_req(4'd2, 16'h0030, 16'h0, 0, r);
    chk(lc - ls == 1 && bcnt == base, "R8 read len 0", 32'(lc - ls), 32'd1);
    exp_cyc(ls, 1, 2, 16'h0030, "R8 address only");
    ls = lc; base = bidx;
    do_req(4'd3, 16'h0030, 16'h0, 0, r);
    chk(lc - ls == 1 && bidx == base, "R8 write len 0", 32'(lc - ls), 32'd1);

    // R9 mailbox
    ls = lc;
    do_req(4'd5, 16'h0, 16'h1234, 0, r);
    chk(lc - ls == 1, "R9 mailbox write cycles", 32'(lc - ls), 32'd1);
    exp_cyc(ls, 1, 1, 16'h1234, "R9 mailbox write");
    chk(mbox_in == 16'h1234, "R9 mailbox value", {16'd0, mbox_in}, 32'h1234);
    ls = lc;
    do_req(4'd4, 16'h0, 16'h0, 0, r);
    chk(lc - ls == 1 && r == MBOX_OUT, "R9 mailbox read", {16'd0, r}, {16'd0, MBOX_OUT});

    // R10 status
    ls = lc;
    do_req(4'd6, 16'h0, 16'h0, 0, r);
    chk(lc - ls == 1, "R10 status cycles", 32'(lc - ls), 32'd1);
    exp_cyc(ls, 0, 3, STAT_VAL, "R10 status read");
    chk(r == STAT_VAL, "R10 status data", {16'd0, r}, {16'd0, STAT_VAL});

    // R11 set then clear
    old = ref_mem[24];
    ls = lc;
    do_req(4'd7, 16'h0030, 16'h00F0, 0, r);
    chk(lc - ls == 4, "R11 set cycles", 32'(lc - ls), 32'd4);
    exp_cyc(ls, 1, 2, 16'h0030, "R11 set addr");
    exp_cyc(ls + 1, 0, 0, old, "R11 set read");
    exp_cyc(ls + 2, 1, 2, 16'h0030, "R11 set addr again");
    exp_cyc(ls + 3, 1, 0, old | 16'h00F0, "R11 set write");
    chk(r == old, "R11 set returns old", {16'd0, r}, {16'd0, old});
    ref_mem[24] = old | 16'h00F0;
    old = ref_mem[24];
    do_req(4'd8, 16'h0030, 16'h0F30, 0, r);
    ref_mem[24] = old & ~16'h0F30;
    chk(dmem[24] == ref_mem[24], "R11 clear result", {16'd0, dmem[24]}, {16'd0, ref_mem[24]});

    // R12 request while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ls = lc;
    req_op = 4'd1; req_addr = 16'h0012; req_wdata = 16'h7777; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 16'h0040; req_wdata = 16'h1111;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    ref_mem[9] = 16'h7777;
    chk(lc - ls == 2, "R12 only one request run", 32'(lc - ls), 32'd2);
    do_req(4'd0, 16'h0040, 16'h0, 0, r);
    chk(r == ref_mem[32], "R12 stray write ignored", {16'd0, r}, {16'd0, ref_mem[32]});

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind, len, w;
      logic [15:0] a, v;
      kind = int'($urandom % 6);
      w = int'($urandom % 100);
      a = 16'(w * 2);
      v = 16'($urandom);
      len = 1 + int'($urandom % 4);
      case (kind)
        0: begin
          do_req(4'd1, a, v, 0, r); ref_mem[w] = v;
          chk(dmem[w] == v, "R5 random write", {16'd0, dmem[w]}, {16'd0, v});
        end
        1: begin
          do_req(4'd0, a, 16'h0, 0, r);
          chk(r == ref_mem[w], "R4 random read", {16'd0, r}, {16'd0, ref_mem[w]});
        end
        2, 3: begin
          m = v; old = ref_mem[w];
          do_req(kind == 2 ? 4'd7 : 4'd8, a, m, 0, r);
          ref_mem[w] = (kind == 2) ? (old | m) : (old & ~m);
          chk(r == old && dmem[w] == ref_mem[w], "R11 random set/clear",
              {dmem[w], r}, {ref_mem[w], old});
        end
        4: begin
          base = bidx;
          do_req(4'd3, a, 16'h0, len, r);
          for (int i = 0; i < len; i++) begin
            ref_mem[w + i] = swp(src[8'(base + i)]);
            chk(dmem[w + i] == ref_mem[w + i], "R7 random burst write",
                {16'd0, dmem[w + i]}, {16'd0, ref_mem[w + i]});
          end
        end
        default: begin
          base = bcnt;
          do_req(4'd2, a, 16'h0, len, r);
          for (int i = 0; i < len; i++)
            chk(rbuf[8'(base + i)] == swp(ref_mem[w + i]), "R6 random burst read",
                {16'd0, rbuf[8'(base + i)]}, {16'd0, swp(ref_mem[w + i])});
        end
      endcase
    end

    chk(bad_pin == 0, "R2 pin rules and register offsets", 32'(bad_pin), 32'd0);
    chk(min_gap >= GAP_CYC, "R3 minimum strobe gap", 32'(min_gap), 32'(GAP_CYC));
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule